// File: doc/BRIEF.md
# Cascadable Up/Down Timer with Trigger Slave Control

This block is a counter with a prescaler, a programmable terminal value and four compare registers. It counts up from zero to the terminal value, or down from the terminal value to zero, and raises an update event each time it wraps. The prescaler, terminal and compare values each have a staging copy and a working copy. Staging of the terminal value and of the compares can be turned on or off. When staging is on, a new value waits until the next update event. The prescaler value always waits.

A trigger input drives a slave controller. The controller can restart the counter, gate it, start it, or step it on each rising edge. A trigger output carries one of eight internal signals, so the trigger output of one timer can drive the trigger input of the next. Software configures the block through a simple write port: a write strobe, a 3-bit address and one data word.

Write addresses: 0 is control, 1 is terminal value, 2 is prescaler, 3 is command, and 4 to 7 are compare 0 to compare 3.

The control word bits are:
- bit 0: run
- bit 1: count down
- bit 2: single shot
- bit 3: stage the terminal value
- bit 4: stage the compares
- bits 7:5: slave mode
- bits 10:8: trigger-out source

Top module: `chain_timer`

## Requirements
- R1: After reset, `cnt_o` is 0, `upd_o` is 0 and `trgo_o` is 0, and the counter holds until the run bit is set.
- R2: Counting up, the counter steps by one per prescaled tick. A tick taken while the count is greater than or equal to the working terminal value clears the count to 0 and causes an update event. `upd_o` is high for the one clock after each update event.
- R3: When control bit 1 is 1, the counter steps down. A tick taken at 0 reloads the terminal value and causes an update event.
- R4: When control bit 3 is 1, a terminal-value write reaches the working copy only at the next update event. When bit 3 is 0, the write takes effect at the same clock edge.
- R5: The prescaler divides ticks by (value + 1). A new prescaler value takes effect only at an update event.
- R6: When control bit 4 is 1, a compare write reaches the working copy only at an update event. When bit 4 is 0, it takes effect at once.
- R7: Writing 1 to command bit 0 causes an update event at that edge. The update loads all working copies, clears the prescaler, and restarts the count: at 0 counting up, or at the terminal value counting down. The bit needs no clearing.
- R8: In slave modes 0 (off), 1 (reset) and 4 (external clock), counting runs only while the run bit is 1. Clearing the run bit freezes the count.
- R9: When control bit 2 is 1, the run bit clears at the next update event. The count is then left at its restart value.
- R10: In slave mode 1, a rising edge on `trig_i` causes an update event.
- R11: In slave mode 2 (gated), the counter runs only while the run bit is 1 and the synchronised `trig_i` is high.
- R12: In slave mode 3 (trigger), a rising edge on `trig_i` sets the run bit. A falling edge does not clear it.
- R13: In slave mode 4, each rising edge of `trig_i` is one count input, and the prescaler still applies.
- R14: The trigger-out source field (control bits 10:8) selects what drives `trgo_o`:

  | Code | Source of `trgo_o` |
  |------|--------------------|
  | 0 | One-clock pulse after each command update |
  | 1 | Run bit |
  | 2 | Update pulse |
  | 3 | One-clock pulse when a newly taken count equals compare 0 |
  | 4 to 7 | Level "count < compare k" for k = 0 to 3 |

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 3 | Configuration write address |
| cfg_wdata_i | input | CNT_W | Configuration write data |
| trig_i | input | 1 | Trigger input, asynchronous, synchronised inside |
| trgo_o | output | 1 | Selected trigger output |
| upd_o | output | 1 | Update event, one clock |
| cnt_o | output | CNT_W | Current count |

## Verification
Assertions check several rules on every cycle:
- A working value that is staged stays unchanged between update events.
- The prescaler never runs past its working value.
- The count is frozen when no tick arrives.
- A command update restarts an up-count at 0.
- Single shot clears the run bit.
- A trigger edge in trigger mode sets the run bit.
- External clock ticks never come on back-to-back clocks.

Only the bench scenarios can show the values that matter across many cycles. These include the exact wrap points with and without staging, prescaler division, and the reload value when counting down. They also include the three-clock latency from a trigger edge to its effect, the gated window, and each trigger-out source.

// File: rtl/chain_timer_pkg.sv
package chain_timer_pkg;
  localparam int N_CMP = 4;

  typedef enum logic [2:0] {
    SM_OFF     = 3'd0,
    SM_RESET   = 3'd1,
    SM_GATED   = 3'd2,
    SM_TRIGGER = 3'd3,
    SM_EXTCLK  = 3'd4
  } slave_mode_e;

  typedef enum logic [2:0] {
    TO_CMDUPD = 3'd0,
    TO_RUN    = 3'd1,
    TO_UPDATE = 3'd2,
    TO_MATCH  = 3'd3,
    TO_REF0   = 3'd4,
    TO_REF1   = 3'd5,
    TO_REF2   = 3'd6,
    TO_REF3   = 3'd7
  } trgo_sel_e;

  localparam logic [2:0] ADDR_CTRL  = 3'd0;
  localparam logic [2:0] ADDR_LIMIT = 3'd1;
  localparam logic [2:0] ADDR_PRESC = 3'd2;
  localparam logic [2:0] ADDR_CMD   = 3'd3;
  localparam logic [2:0] ADDR_CMP0  = 3'd4;

  // control word bits 10:1, run bit kept apart
  typedef struct packed {
    logic [2:0] trgo_sel;
    logic [2:0] slave_mode;
    logic       cmp_buf;
    logic       lim_buf;
    logic       single_shot;
    logic       count_down;
  } ctrl_t;
endpackage

// File: rtl/ct_regs.sv
module ct_regs
  import chain_timer_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             we_i,
  input  logic [2:0]       addr_i,
  input  logic [10:0]      wdata_i,
  input  logic             set_run_i,
  input  logic             upd_evt_i,
  output ctrl_t            ctrl_o,
  output logic             run_en_o,
  output logic             cmd_upd_o,
  output logic             cmd_pulse_o,
  output logic             wr_lim_o,
  output logic             wr_psc_o,
  output logic [N_CMP-1:0] wr_cmp_o
);
  logic wr_ctrl;

  assign wr_ctrl   = we_i && (addr_i == ADDR_CTRL);
  assign wr_lim_o  = we_i && (addr_i == ADDR_LIMIT);
  assign wr_psc_o  = we_i && (addr_i == ADDR_PRESC);
  assign cmd_upd_o = we_i && (addr_i == ADDR_CMD) && wdata_i[0];

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp_dec
    assign wr_cmp_o[k] = we_i && (addr_i == ADDR_CMP0 + 3'(k));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_o      <= '0;
      run_en_o    <= 1'b0;
      cmd_pulse_o <= 1'b0;
    end else begin
      cmd_pulse_o <= cmd_upd_o;
      if (wr_ctrl) begin
        ctrl_o   <= ctrl_t'(wdata_i[10:1]);
        run_en_o <= wdata_i[0];
      end else if (upd_evt_i && ctrl_o.single_shot) begin
        run_en_o <= 1'b0;
      end else if (set_run_i) begin
        run_en_o <= 1'b1;
      end
    end
  end

  a_r9_single_shot_stops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_evt_i && ctrl_o.single_shot && !wr_ctrl) |=> !run_en_o);

  a_r12_trigger_sets_run: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (set_run_i && !wr_ctrl && !(upd_evt_i && ctrl_o.single_shot)) |=> run_en_o);
endmodule

// File: rtl/ct_slave.sv
module ct_slave
  import chain_timer_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       trig_i,
  input  logic [2:0] mode_i,
  input  logic       run_en_i,
  output logic       tick_o,
  output logic       slave_upd_o,
  output logic       set_run_o
);
  logic [1:0] sync_q;
  logic       trig_d_q;
  logic       trig_s;
  logic       rise;

  assign trig_s = sync_q[1];
  assign rise   = trig_s && !trig_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q   <= '0;
      trig_d_q <= 1'b0;
    end else begin
      sync_q   <= {sync_q[0], trig_i};
      trig_d_q <= trig_s;
    end
  end

  always_comb begin
    tick_o      = run_en_i;
    slave_upd_o = 1'b0;
    set_run_o   = 1'b0;
    case (slave_mode_e'(mode_i))
      SM_RESET:   slave_upd_o = rise;
      SM_GATED:   tick_o      = run_en_i && trig_s;
      SM_TRIGGER: set_run_o   = rise;
      SM_EXTCLK:  tick_o      = run_en_i && rise;
      default:    ;
    endcase
  end

  a_r13_ext_ticks_spaced: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_i == SM_EXTCLK && tick_o) |=> (!tick_o || mode_i != SM_EXTCLK));
endmodule

// File: rtl/ct_counter.sv
module ct_counter
  import chain_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  input  logic             ext_upd_i,
  input  logic             count_down_i,
  input  logic             lim_buf_i,
  input  logic             cmp_buf_i,
  input  logic [CNT_W-1:0] wdata_i,
  input  logic             wr_lim_i,
  input  logic             wr_psc_i,
  input  logic [N_CMP-1:0] wr_cmp_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             upd_evt_o,
  output logic             upd_o,
  output logic             match_o,
  output logic [N_CMP-1:0] ref_o
);
  logic [CNT_W-1:0] cnt_q, pre_q, psc_pre_q, psc_act_q, lim_pre_q, lim_act_q;
  logic [N_CMP-1:0][CNT_W-1:0] cmp_pre_q, cmp_act_q;
  logic pre_done, at_end, upd_evt, upd_q, chg_q;

  assign pre_done  = tick_i && (pre_q == psc_act_q);
  assign at_end    = count_down_i ? (cnt_q == '0) : (cnt_q >= lim_act_q);
  assign upd_evt   = ext_upd_i || (pre_done && at_end);
  assign upd_evt_o = upd_evt;
  assign upd_o     = upd_q;
  assign cnt_o     = cnt_q;
  // pulse only on a freshly taken count value
  assign match_o   = chg_q && (cnt_q == cmp_act_q[0]);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q     <= '0;
      pre_q     <= '0;
      psc_pre_q <= '0;
      psc_act_q <= '0;
      lim_pre_q <= '1;
      lim_act_q <= '1;
      upd_q     <= 1'b0;
      chg_q     <= 1'b0;
    end else begin
      upd_q <= upd_evt;
      chg_q <= upd_evt || pre_done;
      if (upd_evt) begin
        pre_q     <= '0;
        psc_act_q <= psc_pre_q;
        cnt_q     <= count_down_i ? lim_pre_q : '0;
      end else begin
        if (tick_i)   pre_q <= pre_done ? '0 : pre_q + 1'b1;
        if (pre_done) cnt_q <= count_down_i ? cnt_q - 1'b1 : cnt_q + 1'b1;
      end
      if (wr_psc_i) psc_pre_q <= wdata_i;
      if (wr_lim_i) lim_pre_q <= wdata_i;
      if (wr_lim_i && !lim_buf_i) lim_act_q <= wdata_i;
      else if (upd_evt)           lim_act_q <= lim_pre_q;
    end
  end

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        cmp_pre_q[k] <= '0;
        cmp_act_q[k] <= '0;
      end else begin
        if (wr_cmp_i[k]) cmp_pre_q[k] <= wdata_i;
        if (wr_cmp_i[k] && !cmp_buf_i) cmp_act_q[k] <= wdata_i;
        else if (upd_evt)               cmp_act_q[k] <= cmp_pre_q[k];
      end
    end
    assign ref_o[k] = cnt_q < cmp_act_q[k];
  end

  a_r2_up_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pre_done && !upd_evt && !count_down_i) |=> cnt_q == $past(cnt_q) + 1'b1);

  a_r4_lim_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_buf_i && !upd_evt) |=> $stable(lim_act_q));

  a_r5_pre_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pre_q <= psc_act_q);

  a_r6_cmp_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmp_buf_i && !upd_evt) |=> $stable(cmp_act_q));

  a_r7_cmd_restart: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ext_upd_i && !count_down_i) |=> (cnt_q == '0 && upd_o));

  a_r8_idle_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !ext_upd_i) |=> ($stable(cnt_q) && $stable(pre_q)));
endmodule

// File: rtl/ct_trgo.sv
module ct_trgo
  import chain_timer_pkg::*;
(
  input  logic [2:0]       sel_i,
  input  logic             cmd_pulse_i,
  input  logic             run_en_i,
  input  logic             upd_i,
  input  logic             match_i,
  input  logic [N_CMP-1:0] ref_i,
  output logic             trgo_o
);
  always_comb begin
    case (trgo_sel_e'(sel_i))
      TO_CMDUPD: trgo_o = cmd_pulse_i;
      TO_RUN:    trgo_o = run_en_i;
      TO_UPDATE: trgo_o = upd_i;
      TO_MATCH:  trgo_o = match_i;
      TO_REF0:   trgo_o = ref_i[0];
      TO_REF1:   trgo_o = ref_i[1];
      TO_REF2:   trgo_o = ref_i[2];
      TO_REF3:   trgo_o = ref_i[3];
      default:   trgo_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/chain_timer.sv
module chain_timer
  import chain_timer_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [2:0]       cfg_addr_i,
  input  logic [CNT_W-1:0] cfg_wdata_i,
  input  logic             trig_i,
  output logic             trgo_o,
  output logic             upd_o,
  output logic [CNT_W-1:0] cnt_o
);
  ctrl_t            ctrl;
  logic             run_en, cmd_upd, cmd_pulse, wr_lim, wr_psc;
  logic [N_CMP-1:0] wr_cmp, refs;
  logic             tick, slave_upd, set_run, upd_evt, match;

  ct_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .we_i        (cfg_we_i),
    .addr_i      (cfg_addr_i),
    .wdata_i     (cfg_wdata_i[10:0]),
    .set_run_i   (set_run),
    .upd_evt_i   (upd_evt),
    .ctrl_o      (ctrl),
    .run_en_o    (run_en),
    .cmd_upd_o   (cmd_upd),
    .cmd_pulse_o (cmd_pulse),
    .wr_lim_o    (wr_lim),
    .wr_psc_o    (wr_psc),
    .wr_cmp_o    (wr_cmp)
  );

  ct_slave u_slave (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .trig_i      (trig_i),
    .mode_i      (ctrl.slave_mode),
    .run_en_i    (run_en),
    .tick_o      (tick),
    .slave_upd_o (slave_upd),
    .set_run_o   (set_run)
  );

  ct_counter #(.CNT_W(CNT_W)) u_counter (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .tick_i       (tick),
    .ext_upd_i    (cmd_upd || slave_upd),
    .count_down_i (ctrl.count_down),
    .lim_buf_i    (ctrl.lim_buf),
    .cmp_buf_i    (ctrl.cmp_buf),
    .wdata_i      (cfg_wdata_i),
    .wr_lim_i     (wr_lim),
    .wr_psc_i     (wr_psc),
    .wr_cmp_i     (wr_cmp),
    .cnt_o        (cnt_o),
    .upd_evt_o    (upd_evt),
    .upd_o        (upd_o),
    .match_o      (match),
    .ref_o        (refs)
  );

  ct_trgo u_trgo (
    .sel_i       (ctrl.trgo_sel),
    .cmd_pulse_i (cmd_pulse),
    .run_en_i    (run_en),
    .upd_i       (upd_o),
    .match_i     (match),
    .ref_i       (refs),
    .trgo_o      (trgo_o)
  );
endmodule

// File: tb/chain_timer_tb.sv
module chain_timer_tb;
  localparam int W = 16;
  localparam logic [15:0] RUN = 16'h0001, DOWN = 16'h0002, OPM = 16'h0004,
                          LBUF = 16'h0008, CBUF = 16'h0010;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic cfg_we = 1'b0;
  logic [2:0] cfg_addr = '0;
  logic [W-1:0] cfg_wdata = '0;
  logic trig = 1'b0;
  logic trgo, upd;
  logic [W-1:0] cnt;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { string req; int sig; int exp; } exp_t;
  exp_t exp_q[$];

  always #10 clk = ~clk;

  chain_timer #(.CNT_W(W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr),
    .cfg_wdata_i(cfg_wdata), .trig_i(trig), .trgo_o(trgo), .upd_o(upd), .cnt_o(cnt)
  );

  function automatic logic [15:0] sm(int m);  return 16'(m << 5); endfunction
  function automatic logic [15:0] tsel(int s); return 16'(s << 8); endfunction

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // driver side: 0 = cnt_o, 1 = upd_o, 2 = trgo_o
  task automatic expect_val(input string req, input int sig, input int e);
    exp_t it;
    it.req = req; it.sig = sig; it.exp = e;
    exp_q.push_back(it);
    wait (exp_q.size() == 0);
  endtask

  // monitor side
  initial begin
    forever begin
      exp_t it;
      int got;
      wait (exp_q.size() != 0);
      it = exp_q[0];
      case (it.sig)
        0: got = int'(cnt);
        1: got = int'(upd);
        default: got = int'(trgo);
      endcase
      checks++;
      if (got != it.exp) begin
        errors++;
        $display("FAIL %s sig%0d got %0d expected %0d", it.req, it.sig, got, it.exp);
      end
      void'(exp_q.pop_front());
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog got 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    tick(3);
    rst_ni = 1'b1;
    tick(1);
    expect_val("R1 cnt", 0, 0);
    expect_val("R1 upd", 1, 0);
    expect_val("R1 trgo", 2, 0);

    // R2 up count and wrap
    wr(1, 16'd4);
    wr(0, RUN);
    tick(3); expect_val("R2 count", 0, 3);
    tick(2); expect_val("R2 wrap", 0, 0); expect_val("R2 upd pulse", 1, 1);
    tick(1); expect_val("R2 upd low", 1, 0);
    wr(0, 16'd0);
    tick(5); expect_val("R8 frozen", 0, 2);

    // R4 staged limit
    wr(0, LBUF);
    wr(1, 16'd9);
    wr(0, LBUF | RUN);
    tick(3); expect_val("R4 old limit wrap", 0, 0);
    tick(9); expect_val("R4 new limit", 0, 9);
    tick(1); expect_val("R4 new wrap", 0, 0);
    wr(0, LBUF);

    // R4 direct limit
    wr(0, RUN);
    tick(2); expect_val("R4 pre", 0, 3);
    wr(1, 16'd5);
    tick(1); expect_val("R4 direct", 0, 5);
    tick(1); expect_val("R4 direct wrap", 0, 0); expect_val("R4 direct upd", 1, 1);
    wr(0, 16'd0);

    // R5 prescaler, R7 command update, R14 source 0
    wr(2, 16'd2);
    wr(3, 16'd1);
    expect_val("R7 restart", 0, 0); expect_val("R7 upd", 1, 1);
    expect_val("R14 cmd pulse", 2, 1);
    wr(0, RUN);
    tick(2); expect_val("R5 div hold", 0, 0);
    tick(1); expect_val("R5 div step", 0, 1);
    tick(3); expect_val("R5 div step2", 0, 2);
    wr(0, 16'd0);
    wr(2, 16'd0);
    wr(3, 16'd1);

    // R3 down count
    wr(0, DOWN | RUN);
    tick(1); expect_val("R3 reload", 0, 5); expect_val("R3 upd", 1, 1);
    tick(2); expect_val("R3 step", 0, 3);
    wr(0, DOWN);
    wr(3, 16'd1);
    expect_val("R7 down restart", 0, 5);
    wr(0, 16'd0);
    wr(3, 16'd1);

    // R9 single shot, R14 source 1
    wr(0, OPM | RUN | tsel(1));
    expect_val("R14 run src", 2, 1);
    tick(5); expect_val("R9 top", 0, 5);
    tick(1); expect_val("R9 wrap", 0, 0); expect_val("R9 run cleared", 2, 0);
    tick(4); expect_val("R9 stopped", 0, 0);

    // R14 match and ref, R6 compare staging
    wr(4, 16'd3);
    wr(0, RUN | tsel(3));
    tick(3); expect_val("R14 match", 2, 1);
    tick(1); expect_val("R14 match end", 2, 0);
    wr(0, RUN | tsel(4));
    expect_val("R14 ref low", 2, 0);
    tick(1); expect_val("R14 ref high", 2, 1);
    wr(0, CBUF | tsel(4));
    wr(4, 16'd0);
    expect_val("R6 staged cmp", 2, 1);
    wr(3, 16'd1);
    expect_val("R6 cmp loaded", 2, 0);
    wr(0, tsel(2));
    wr(3, 16'd1);
    expect_val("R14 upd src", 2, 1);
    tick(1); expect_val("R14 upd src end", 2, 0);

    // R10 slave reset
    wr(0, RUN | sm(1));
    tick(2); expect_val("R10 pre", 0, 2);
    trig = 1'b1;
    tick(3); expect_val("R10 restart", 0, 0); expect_val("R10 upd", 1, 1);
    tick(1); expect_val("R10 after", 0, 1);
    trig = 1'b0;
    wr(0, 16'd0);

    // R11 gated
    wr(3, 16'd1);
    tick(2);
    wr(0, RUN | sm(2));
    tick(4); expect_val("R11 gate low", 0, 0);
    trig = 1'b1;
    tick(5); expect_val("R11 gate open", 0, 3);
    trig = 1'b0;
    tick(4); expect_val("R11 gate closed", 0, 5);

    // R12 trigger start
    wr(0, 16'd0);
    wr(3, 16'd1);
    wr(0, sm(3));
    tick(3); expect_val("R12 idle", 0, 0);
    trig = 1'b1;
    tick(5); expect_val("R12 started", 0, 2);
    trig = 1'b0;
    tick(2); expect_val("R12 keeps running", 0, 4);

    // R13 external clock
    wr(0, 16'd0);
    wr(3, 16'd1);
    wr(0, RUN | sm(4));
    tick(6); expect_val("R13 no edges", 0, 0);
    for (int i = 0; i < 3; i++) begin
      trig = 1'b1; tick(2);
      trig = 1'b0; tick(2);
    end
    tick(3); expect_val("R13 edge count", 0, 3);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule